// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms the effective address for word and byte loads and stores in a 32-bit load/store processor, and the result of the two address-arithmetic instructions used to build constants. It receives the base and index register read values, the base register specifier, a 16-bit immediate and a 5-bit operation code. It returns the 32-bit sum together with the memory-operation attributes: direction, access size, zero-extension for byte loads, and a request to write the address back into the base register.

A base specifier of zero always supplies the value zero instead of the register contents. A lower-form constant from register zero followed by an upper-form add on that result can therefore produce any 32-bit value. The result can leave combinationally or through one register stage, as chosen by a parameter. A valid bit travels with each result.

Operation code: `op[1:0]` selects the kind (0 lower constant, 1 upper constant, 2 load, 3 store). `op[2]` selects the indexed form. `op[3]` requests base update. `op[4]` selects byte size. Bits 3 and 4 apply only to loads and stores.

Top module: `eff_addr_unit`

## Requirements
- R1: A non-indexed operation of kind 0, 2 or 3 gives `addr` = base operand + sign-extended 16-bit `imm`.
- R2: A non-indexed operation of kind 1 gives `addr` = base operand + (`imm` shifted left by 16, low half zero).
- R3: When `base_idx` is 0, the base operand is zero whatever `base_val` holds, for every kind and form.
- R4: When `op[2]` is 1, `addr` = base operand + `index_val`, and `imm` has no effect.
- R5: A load or store with `op[3]`=1 and `base_idx`≠0 raises `upd_en` with `upd_idx` = `base_idx`.
- R6: A load or store with `op[3]`=1 and `base_idx`=0 raises `upd_bad`, keeps `upd_en` low and sets `upd_idx` to 0.
- R7: Constant kinds (0, 1) and loads and stores with `op[3]`=0 drive `upd_en`, `upd_bad` and `upd_idx` to 0.
- R8: `mem_op` is 1 for kinds 2 and 3. `store_op` is 1 for kind 3. `size_byte` equals `op[4]` for loads and stores and is 0 for constants. `load_zext` is 1 only for byte loads.
- R9: With `OUT_REG`=1, every valid input produces exactly one result with `out_valid` high one clock later. After reset `out_valid` is 0, and all control outputs are 0 whenever `out_valid` is 0.
- R10: A lower form from register 0 with immediate C[15:0], followed by an upper form on that result with immediate C[31:16]+C[15], yields the 32-bit constant C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 5 | Kind, indexed, update and byte bits |
| base_idx | input | 5 | Base register specifier |
| base_val | input | 32 | Base register read value |
| index_val | input | 32 | Index register read value |
| imm | input | 16 | Immediate field |
| out_valid | output | 1 | Result present |
| addr | output | 32 | Effective address or constant result |
| mem_op | output | 1 | Load or store |
| store_op | output | 1 | Store |
| size_byte | output | 1 | Byte access (else word) |
| load_zext | output | 1 | Zero-extend the loaded byte |
| upd_en | output | 1 | Write `addr` back to the base register |
| upd_idx | output | 5 | Register to write back |
| upd_bad | output | 1 | Update requested with base register 0 |

## Verification
The bench aims at the boundaries of the immediate. Negative displacements test sign extension: a design that zero-extends them gives an address 64 KiB too high. Upper-form immediates with bit 15 set test the shift: a design that sign-extends or fails to shift returns the wrong upper half. Base specifier 0 paired with a nonzero `base_val` catches a design that reads the register file instead of supplying zero. Update forms on register 0 catch a write enable that leaks. Constant, non-update and indexed operations that carry stray update, byte or immediate bits catch decode that listens to fields it should ignore. Lower/upper constant pairs, including low halves with bit 15 set, confirm that the carry into the upper half is handled.

// File: rtl/eff_addr_unit.sv
module eff_addr_unit #(
  parameter int XLEN    = 32,
  parameter int IMM_W   = 16,
  parameter int RW      = 5,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [4:0]       op,
  input  logic [RW-1:0]    base_idx,
  input  logic [XLEN-1:0]  base_val,
  input  logic [XLEN-1:0]  index_val,
  input  logic [IMM_W-1:0] imm,
  output logic             out_valid,
  output logic [XLEN-1:0]  addr,
  output logic             mem_op,
  output logic             store_op,
  output logic             size_byte,
  output logic             load_zext,
  output logic             upd_en,
  output logic [RW-1:0]    upd_idx,
  output logic             upd_bad
);

  localparam int PW = 1 + XLEN + 6 + RW;

  logic            base_zero, kind_hi, c_mem, c_st, c_byte, c_zext;
  logic            upd_req, c_upd, c_bad;
  logic [RW-1:0]   c_uidx;
  logic [XLEN-1:0] base_op, disp_lo, disp_hi, second, c_addr;
  logic [PW-1:0]   c_bus, r_bus;

  assign base_zero = (base_idx == '0);
  assign base_op   = base_zero ? '0 : base_val;
  assign kind_hi   = (op[1:0] == 2'b01);

  assign disp_lo = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign disp_hi = {{(XLEN-IMM_W){1'b0}}, imm} << IMM_W;

  always_comb begin
    if (op[2])        second = index_val;
    else if (kind_hi) second = disp_hi;
    else              second = disp_lo;
  end

  assign c_addr = base_op + second;

  assign c_mem   = in_valid & op[1];
  assign c_st    = c_mem & op[0];
  assign c_byte  = c_mem & op[4];
  assign c_zext  = c_byte & ~op[0];
  assign upd_req = c_mem & op[3];
  assign c_upd   = upd_req & ~base_zero;
  assign c_bad   = upd_req & base_zero;
  assign c_uidx  = c_upd ? base_idx : '0;

  assign c_bus = {in_valid, c_addr, c_mem, c_st, c_byte, c_zext, c_upd, c_bad, c_uidx};

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_bus <= '0;
        else        r_bus <= c_bus;
      end
    end else begin : g_comb
      assign r_bus = c_bus;
    end
  endgenerate

  assign {out_valid, addr, mem_op, store_op, size_byte, load_zext, upd_en, upd_bad, upd_idx} = r_bus;

endmodule

module eff_addr_unit_chk #(
  parameter int RW      = 5,
  parameter bit OUT_REG = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic          mem_op,
  input logic          store_op,
  input logic          size_byte,
  input logic          load_zext,
  input logic          upd_en,
  input logic [RW-1:0] upd_idx,
  input logic          upd_bad
);

  a_r6_bad_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    upd_bad |-> (!upd_en && upd_idx == '0));

  a_r5_write_target_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> (upd_idx != '0));

  a_r7_update_only_on_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en || upd_bad) |-> mem_op);

  a_r8_zext_byte_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_zext |-> (size_byte && mem_op && !store_op));

  a_r8_const_is_word: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_op |-> (!size_byte && !store_op));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(mem_op || upd_en || upd_bad));

  generate
    if (OUT_REG) begin : g_lat
      a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));
    end
  endgenerate

endmodule

bind eff_addr_unit eff_addr_unit_chk #(.RW(RW), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .mem_op(mem_op), .store_op(store_op), .size_byte(size_byte),
  .load_zext(load_zext), .upd_en(upd_en), .upd_idx(upd_idx), .upd_bad(upd_bad)
);

// File: tb/sim_eff_addr_unit.sv
module sim_eff_addr_unit;
  localparam int PERIOD = 10;
  localparam logic [4:0] K_LO = 5'd0, K_HI = 5'd1, K_LD = 5'd2, K_ST = 5'd3;
  localparam logic [4:0] F_IDX = 5'd4, F_UPD = 5'd8, F_BYTE = 5'd16;

  typedef struct {
    logic [42:0] exp;
    string       tag;
  } item_t;

  logic        clk = 0, rst_n = 0, in_valid = 0;
  logic [4:0]  op = '0, base_idx = '0;
  logic [31:0] base_val = '0, index_val = '0;
  logic [15:0] imm = '0;
  logic        out_valid, mem_op, store_op, size_byte, load_zext, upd_en, upd_bad;
  logic [31:0] addr;
  logic [4:0]  upd_idx;

  int total = 0, bad = 0;
  item_t q[$];

  always #(PERIOD/2) clk = ~clk;

  eff_addr_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .base_idx(base_idx),
    .base_val(base_val), .index_val(index_val), .imm(imm), .out_valid(out_valid),
    .addr(addr), .mem_op(mem_op), .store_op(store_op), .size_byte(size_byte),
    .load_zext(load_zext), .upd_en(upd_en), .upd_idx(upd_idx), .upd_bad(upd_bad)
  );

  function automatic logic [42:0] model(logic [4:0] o, logic [4:0] bi, logic [31:0] bv,
                                        logic [31:0] xv, logic [15:0] im);
    logic [31:0] b, s, a;
    logic m, st, by, zx, rq, ue, ub;
    logic [4:0] ui;
    b = (bi == 0) ? 32'd0 : bv;
    if (o[2])              s = xv;
    else if (o[1:0] == 1)  s = {im, 16'h0000};
    else                   s = {{16{im[15]}}, im};
    a  = b + s;
    m  = o[1];
    st = m & o[0];
    by = m & o[4];
    zx = by & ~st;
    rq = m & o[3];
    ue = rq & (bi != 0);
    ub = rq & (bi == 0);
    ui = ue ? bi : 5'd0;
    return {a, m, st, by, zx, ue, ub, ui};
  endfunction

  task automatic drive(string tag, logic [4:0] o, logic [4:0] bi, logic [31:0] bv,
                       logic [31:0] xv, logic [15:0] im);
    item_t it;
    @(posedge clk); #1;
    in_valid = 1; op = o; base_idx = bi; base_val = bv; index_val = xv; imm = im;
    it.exp = model(o, bi, bv, xv, im);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drive_const(string tag, logic [31:0] c);
    item_t it;
    logic [15:0] hi;
    logic [31:0] lo_res;
    lo_res = {{16{c[15]}}, c[15:0]};
    hi = c[31:16] + {15'd0, c[15]};
    @(posedge clk); #1;
    in_valid = 1; op = K_LO; base_idx = 0; base_val = 32'hDEAD_BEEF; index_val = 0; imm = c[15:0];
    it.exp = {lo_res, 11'd0}; it.tag = tag; q.push_back(it);
    @(posedge clk); #1;
    op = K_HI; base_idx = 5'd7; base_val = lo_res; imm = hi;
    it.exp = {c, 11'd0}; it.tag = tag; q.push_back(it);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 0; op = '0; base_idx = '0; imm = '0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      logic [42:0] act;
      item_t it;
      act = {addr, mem_op, store_op, size_byte, load_zext, upd_en, upd_bad, upd_idx};
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R9: unexpected result act=%h exp=none", act);
      end else begin
        it = q.pop_front();
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: act=%h exp=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 5000);
    bad++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 3);
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || upd_en !== 1'b0) begin
      bad++;
      $display("FAIL R9 reset: act=%b%b exp=00", out_valid, upd_en);
    end
    rst_n = 1;

    drive("R1", K_LO, 5'd1, 32'h0000_1000, 32'h0, 16'h006F);
    drive("R1", K_LO, 5'd2, 32'h0000_1000, 32'h0, 16'hFFD3);
    drive("R1", K_LD, 5'd4, 32'h8000_0000, 32'h0, 16'h8000);
    drive("R2", K_HI, 5'd1, 32'h0000_0010, 32'h0, 16'h006F);
    drive("R2", K_HI, 5'd3, 32'h0000_1234, 32'h0, 16'hF00F);
    drive("R3", K_LO, 5'd0, 32'hFFFF_FFFF, 32'h0, 16'h006F);
    drive("R3", K_HI, 5'd0, 32'h1111_1111, 32'h0, 16'h8001);
    drive("R3", K_ST, 5'd0, 32'hAAAA_AAAA, 32'h0, 16'h0004);
    drive("R4", K_LD | F_IDX, 5'd1, 32'h0000_0100, 32'h0000_0024, 16'hFFFF);
    drive("R4", K_LO | F_IDX, 5'd9, 32'h7FFF_FFFF, 32'h0000_0001, 16'h1234);
    drive("R4", K_ST | F_IDX, 5'd0, 32'h5555_5555, 32'h0000_0040, 16'h7777);
    drive("R5", K_LD | F_UPD, 5'd1, 32'h0000_2000, 32'h0, 16'h0004);
    drive("R5", K_ST | F_UPD | F_IDX | F_BYTE, 5'd31, 32'h0000_3000, 32'h0000_0003, 16'h0);
    drive("R6", K_LD | F_UPD, 5'd0, 32'h0000_2000, 32'h0, 16'h0004);
    drive("R6", K_ST | F_UPD | F_BYTE, 5'd0, 32'h1, 32'h0, 16'hFFFC);
    drive("R7", K_LO | F_UPD | F_BYTE, 5'd5, 32'h0000_0050, 32'h0, 16'h0001);
    drive("R7", K_HI | F_UPD, 5'd6, 32'h0, 32'h0, 16'h0002);
    drive("R7", K_ST, 5'd8, 32'h0000_0400, 32'h0, 16'h0008);
    drive("R8", K_LD | F_BYTE, 5'd2, 32'h0000_0500, 32'h0, 16'h0003);
    drive("R8", K_ST | F_BYTE, 5'd2, 32'h0000_0500, 32'h0, 16'h0003);
    drive("R8", K_LD, 5'd2, 32'h0000_0500, 32'h0, 16'h0003);
    idle();
    idle();
    drive("R9", K_LD | F_UPD, 5'd12, 32'h0000_0600, 32'h0, 16'h0010);
    idle();
    drive_const("R10", 32'h1234_5678);
    drive_const("R10", 32'hDEAD_BEEF);
    drive_const("R10", 32'h0000_8000);
    drive_const("R10", 32'hFFFF_FFFF);
    drive_const("R10", 32'h7FFF_8001);
    idle();
    repeat (4) @(posedge clk);
    @(negedge clk);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R9: pending act=%0d exp=0", q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule